// File: doc/BRIEF.md
# Emulated PHY Link Resolution Controller

This block takes the place of a transceiver on one switch port. It does not run a real negotiation. Instead it settles the port MAC's duplex and its two pause enables from a small set of inputs: a mode select, a live duplex pin compared against a polarity strap, an auto-negotiation enable bit, an advertisement register, and a manual flow-control register. An emulated link partner always reports the same pause abilities that the block advertises.

Software reaches the registers through a plain read/write port with a two-bit word address. A read returns data one cycle after the request. There are two soft-reset paths. The first is a self-clearing bit in the control word, which completes in a single cycle. The second is a request from the chip's global reset-control logic, which holds the block in reset for a parameterised number of clock cycles. That interval stands for roughly 102 microseconds.

Top module: `phy_link_resolver`

## Requirements
- R1: After hardware reset, reads return these values. Control (address 0) returns 0x1100: auto-negotiation enable is bit 12 and duplex is bit 8, both 1. Advertisement (address 1) returns 0x0C00: symmetric pause is bit 10 and asymmetric pause is bit 11, both 1. The manual word (address 3) has its writable bits 2:0 at 0.
- R2: When `macMode`=1 and auto-negotiation is enabled, `fullDuplex` is 1 exactly when `duplexPin` equals `duplexStrap`. It follows the pin combinationally, with no clock edge needed and no latching.
- R3: When auto-negotiation is disabled, `fullDuplex` equals control bit 8, in either mode.
- R4: The partner word (address 2) always reads back advertisement bits 11 and 10 in the same positions, with all other bits 0. Writes to address 2 change nothing.
- R5: When `macMode`=0, auto-negotiation is enabled and manual select (bit 0 of address 3) is 0, the block behaves as follows. `fullDuplex`=1, and both pause enables follow the symmetric/asymmetric resolution table applied to its own advertisement and the mirrored partner. With a mirrored partner, this makes both enables equal to advertisement bit 10.
- R6: When auto-negotiation is disabled, or manual select is 1, or `macMode`=1, the pause enables come from the manual word. `txPauseEn` takes bit 2 and `rxPauseEn` takes bit 1.
- R7: Whenever `fullDuplex` is 0, both `txPauseEn` and `rxPauseEn` are 0.
- R8: A write to address 0 with bit 15 set returns every register to its R1 value at that clock edge, and the rest of that write is dropped. Bit 15 always reads back as 0.
- R9: A one-cycle pulse on `globalRstReq` drives `globalRstBusy` high for exactly RST_CYCLES cycles, after which it clears by itself. Over that interval all registers are held at their R1 values, and register writes and repeated requests are ignored.
- R10: `rdData` is updated on the edge where `rdEn` is sampled high and holds otherwise. Manual word bits 3, 4 and 5 read back the live `fullDuplex`, `txPauseEn` and `rxPauseEn`. Writes to bits 5:3 have no effect.
- R11: Taking `rstN` low at any time restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, asynchronous |
| macMode | input | 1 | 1: port runs against an external PHY; 0: block acts as the PHY |
| duplexPin | input | 1 | Live duplex indication from the outside |
| duplexStrap | input | 1 | Polarity reference compared with duplexPin |
| wrEn | input | 1 | Register write request |
| rdEn | input | 1 | Register read request |
| addr | input | 2 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid one cycle after rdEn |
| globalRstReq | input | 1 | One-cycle request from the global reset-control bit |
| globalRstBusy | output | 1 | High while the timed reset runs (the self-clearing bit) |
| fullDuplex | output | 1 | Resolved duplex for the port MAC |
| txPauseEn | output | 1 | Resolved transmit-pause enable |
| rxPauseEn | output | 1 | Resolved receive-pause enable |

## Verification
The bench sweeps every combination of the following inputs and checks the three resolved outputs and the status readback against an arithmetic model: mode, pin, strap, auto-negotiation bit, duplex bit, the three manual bits and the two advertisement bits. Several design errors would show up in this sweep. A design that latched the pin would miss the same-cycle pin toggle. One that forgot the half-duplex gate would report pause in a mismatched MAC-mode case. One that took pause from the advertisement in MAC mode would disagree whenever the manual bits differ from bit 10. The timed reset is measured by counting busy cycles exactly, and by attempting writes and a second request inside the window. An off-by-one counter, a request that retriggers, or a leaking write would each change the count or the registers read back afterwards.

// File: rtl/plr_pkg.sv
package plr_pkg;

  typedef struct packed {
    logic wrCtrl;
    logic wrAdv;
    logic wrMan;
    logic clearAll;
  } plr_strobe_t;

  localparam int unsigned CTRL_ADDR    = 0;
  localparam int unsigned ADV_ADDR     = 1;
  localparam int unsigned PARTNER_ADDR = 2;
  localparam int unsigned MANUAL_ADDR  = 3;

  localparam int unsigned CTRL_RST_BIT = 15;
  localparam int unsigned CTRL_AN_BIT  = 12;
  localparam int unsigned CTRL_DUP_BIT = 8;

  localparam int unsigned ADV_SYM_BIT  = 10;
  localparam int unsigned ADV_ASYM_BIT = 11;

  localparam int unsigned MAN_SEL_BIT  = 0;
  localparam int unsigned MAN_RX_BIT   = 1;
  localparam int unsigned MAN_TX_BIT   = 2;
  localparam int unsigned MAN_FD_STAT  = 3;
  localparam int unsigned MAN_TX_STAT  = 4;
  localparam int unsigned MAN_RX_STAT  = 5;

endpackage

// File: rtl/plr_ctrl.sv
module plr_ctrl
  import plr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned RST_CYCLES = 10200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              softRstBit,
  input  logic              globalRstReq,
  output plr_strobe_t       st,
  output logic              busy
);

  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] holdCnt;
  logic wrOk;
  logic hitCtrl, hitAdv, hitMan;
  logic softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (globalRstReq && holdCnt == '0) begin
      holdCnt <= CNT_W'(RST_CYCLES);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign busy    = (holdCnt != '0);
  assign wrOk    = wrEn && !busy && !globalRstReq;
  assign hitCtrl = (addr == ADDR_W'(CTRL_ADDR));
  assign hitAdv  = (addr == ADDR_W'(ADV_ADDR));
  assign hitMan  = (addr == ADDR_W'(MANUAL_ADDR));
  assign softRst = wrOk && hitCtrl && softRstBit;

  always_comb begin
    st          = '0;
    st.clearAll = busy || globalRstReq || softRst;
    st.wrCtrl   = wrOk && hitCtrl && !softRstBit;
    st.wrAdv    = wrOk && hitAdv;
    st.wrMan    = wrOk && hitMan;
  end

  // R9: the hold counter never exceeds its programmed length
  a_r9_cnt_bound : assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_W'(RST_CYCLES));

  // R9: once running, the hold interval is not cut short
  a_r9_no_early_end : assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt > CNT_W'(1)) |=> busy);

  // R9: a request while idle always starts the interval
  a_r9_start : assert property (@(posedge clk) disable iff (!rstN)
    (globalRstReq && !busy) |=> busy);

endmodule

// File: rtl/plr_datapath.sv
module plr_datapath
  import plr_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  plr_strobe_t       st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              macMode,
  input  logic              duplexPin,
  input  logic              duplexStrap,
  output logic [DATA_W-1:0] rdData,
  output logic              fullDuplex,
  output logic              txPauseEn,
  output logic              rxPauseEn
);

  logic anEn, dupBit, advSym, advAsym, manSel, manRx, manTx;
  logic partnerSym, partnerAsym;
  logic useManual, txAuto, rxAuto;
  logic [DATA_W-1:0] rdMux;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anEn <= 1'b1; dupBit <= 1'b1; advSym <= 1'b1; advAsym <= 1'b1;
      manSel <= 1'b0; manRx <= 1'b0; manTx <= 1'b0;
    end else if (st.clearAll) begin
      anEn <= 1'b1; dupBit <= 1'b1; advSym <= 1'b1; advAsym <= 1'b1;
      manSel <= 1'b0; manRx <= 1'b0; manTx <= 1'b0;
    end else begin
      if (st.wrCtrl) begin
        anEn   <= wrData[CTRL_AN_BIT];
        dupBit <= wrData[CTRL_DUP_BIT];
      end
      if (st.wrAdv) begin
        advSym  <= wrData[ADV_SYM_BIT];
        advAsym <= wrData[ADV_ASYM_BIT];
      end
      if (st.wrMan) begin
        manSel <= wrData[MAN_SEL_BIT];
        manRx  <= wrData[MAN_RX_BIT];
        manTx  <= wrData[MAN_TX_BIT];
      end
    end
  end

  // emulated partner mirrors the local pause advertisement
  assign partnerSym  = advSym;
  assign partnerAsym = advAsym;

  always_comb begin
    if (!anEn)        fullDuplex = dupBit;
    else if (macMode) fullDuplex = (duplexPin == duplexStrap);
    else              fullDuplex = 1'b1;
  end

  assign useManual = !anEn || manSel || macMode;
  assign txAuto = (advSym && partnerSym) ||
                  (!advSym && advAsym && partnerSym && partnerAsym);
  assign rxAuto = (advSym && partnerSym) ||
                  (advSym && advAsym && !partnerSym && partnerAsym);
  assign txPauseEn = fullDuplex && (useManual ? manTx : txAuto);
  assign rxPauseEn = fullDuplex && (useManual ? manRx : rxAuto);

  always_comb begin
    rdMux = '0;
    unique case (addr)
      ADDR_W'(CTRL_ADDR): begin
        rdMux[CTRL_AN_BIT]  = anEn;
        rdMux[CTRL_DUP_BIT] = dupBit;
      end
      ADDR_W'(ADV_ADDR): begin
        rdMux[ADV_SYM_BIT]  = advSym;
        rdMux[ADV_ASYM_BIT] = advAsym;
      end
      ADDR_W'(PARTNER_ADDR): begin
        rdMux[ADV_SYM_BIT]  = partnerSym;
        rdMux[ADV_ASYM_BIT] = partnerAsym;
      end
      default: begin
        rdMux[MAN_SEL_BIT] = manSel;
        rdMux[MAN_RX_BIT]  = manRx;
        rdMux[MAN_TX_BIT]  = manTx;
        rdMux[MAN_FD_STAT] = fullDuplex;
        rdMux[MAN_TX_STAT] = txPauseEn;
        rdMux[MAN_RX_STAT] = rxPauseEn;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  // R7: half duplex never carries pause
  a_r7_half_quiet : assert property (@(posedge clk) disable iff (!rstN)
    !fullDuplex |-> (!txPauseEn && !rxPauseEn));

  // R8 / R9: any clear leaves every register at its default
  a_r8_defaults : assert property (@(posedge clk) disable iff (!rstN)
    st.clearAll |=> (anEn && dupBit && advSym && advAsym && !manSel && !manRx && !manTx));

  // R10: read data holds when no read is requested
  a_r10_rd_hold : assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R5: acting as the PHY with negotiation, pause is symmetric and follows bit 10
  a_r5_phy_pause : assert property (@(posedge clk) disable iff (!rstN)
    (!macMode && anEn && !manSel) |->
      (fullDuplex && txPauseEn == advSym && rxPauseEn == advSym));

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
  import plr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RST_CYCLES = 10200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              macMode,
  input  logic              duplexPin,
  input  logic              duplexStrap,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              globalRstReq,
  output logic              globalRstBusy,
  output logic              fullDuplex,
  output logic              txPauseEn,
  output logic              rxPauseEn
);

  plr_strobe_t st;

  plr_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .softRstBit(wrData[CTRL_RST_BIT]), .globalRstReq(globalRstReq),
    .st(st), .busy(globalRstBusy)
  );

  plr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .rdEn(rdEn),
    .addr(addr), .macMode(macMode), .duplexPin(duplexPin),
    .duplexStrap(duplexStrap), .rdData(rdData), .fullDuplex(fullDuplex),
    .txPauseEn(txPauseEn), .rxPauseEn(rxPauseEn)
  );

endmodule

// File: tb/test_phy_link_resolver.sv
module test_phy_link_resolver;

  localparam int unsigned N_RST = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic macMode = 1'b0, duplexPin = 1'b0, duplexStrap = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic globalRstReq = 1'b0;
  logic globalRstBusy, fullDuplex, txPauseEn, rxPauseEn;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phy_link_resolver #(.RST_CYCLES(N_RST)) i_phy_link_resolver (
    .clk(clk), .rstN(rstN), .macMode(macMode), .duplexPin(duplexPin),
    .duplexStrap(duplexStrap), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .globalRstReq(globalRstReq),
    .globalRstBusy(globalRstBusy), .fullDuplex(fullDuplex),
    .txPauseEn(txPauseEn), .rxPauseEn(rxPauseEn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  // model: returns {fd, tx, rx}
  function automatic logic [2:0] model(input logic mac, an, dup, pin, strap,
                                       sel, mtx, mrx, sym);
    logic fd, man, tx, rx;
    fd  = !an ? dup : (mac ? (pin == strap) : 1'b1);
    man = !an || sel || mac;
    tx  = fd & (man ? mtx : sym);
    rx  = fd & (man ? mrx : sym);
    return {fd, tx, rx};
  endfunction

  initial begin
    #1_500_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int busyCount;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R11: defaults after hardware reset
    rd(2'd0, d); check("R1 ctrl default", d, 16'h1100);
    rd(2'd1, d); check("R1 adv default", d, 16'h0C00);
    rd(2'd2, d); check("R4 partner default", d, 16'h0C00);
    rd(2'd3, d); check("R1 manual default (PHY, AN)", d, 16'h0038);

    // exhaustive sweep R2 R3 R5 R6 R7 R10
    for (int v = 0; v < 1024; v++) begin
      logic mac, an, dup, pin, strap, sel, mtx, mrx, sym, asym;
      logic [2:0] e;
      {mac, an, dup, pin, strap, sel, mtx, mrx, sym, asym} = v[9:0];
      wr(2'd0, {3'b000, an, 3'b000, dup, 8'h00});
      wr(2'd1, {4'b0000, asym, sym, 10'h000});
      wr(2'd3, {10'h000, 3'b111, mtx, mrx, sel}); // status bits written as 1: ignored (R10)
      @(negedge clk);
      macMode = mac; duplexPin = pin; duplexStrap = strap;
      #1;
      e = model(mac, an, dup, pin, strap, sel, mtx, mrx, sym);
      check("R2/R3 fullDuplex", {15'd0, fullDuplex}, {15'd0, e[2]});
      check("R5/R6/R7 txPauseEn", {15'd0, txPauseEn}, {15'd0, e[1]});
      check("R5/R6/R7 rxPauseEn", {15'd0, rxPauseEn}, {15'd0, e[0]});
      rd(2'd3, d);
      check("R10 manual readback", d, {10'd0, e[0], e[1], e[2], mtx, mrx, sel});
      if (v[5:0] == 6'd0) begin
        rd(2'd2, d); check("R4 partner mirror", d, {4'd0, asym, sym, 10'd0});
      end
    end

    // R2: pin toggled with no clock edge in between
    wr(2'd0, 16'h1100);
    @(negedge clk);
    macMode = 1'b1; duplexStrap = 1'b1; duplexPin = 1'b1; #1;
    check("R2 pin equal", {15'd0, fullDuplex}, 16'd1);
    duplexPin = 1'b0; #1;
    check("R2 pin toggled unclocked", {15'd0, fullDuplex}, 16'd0);
    check("R7 half no tx", {15'd0, txPauseEn}, 16'd0);
    duplexPin = 1'b1; #1;
    check("R2 pin restored", {15'd0, fullDuplex}, 16'd1);

    // R4: write to partner ignored
    wr(2'd1, 16'h0400);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); check("R4 partner write ignored", d, 16'h0400);

    // R8: control soft reset
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0007);
    wr(2'd0, 16'h8000);
    rd(2'd0, d); check("R8 ctrl after soft reset, bit15 clear", d, 16'h1100);
    rd(2'd1, d); check("R8 adv after soft reset", d, 16'h0C00);
    rd(2'd3, d); check("R8 manual after soft reset", d & 16'h0007, 16'h0000);

    // R9: timed global reset
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    @(negedge clk); globalRstReq = 1'b1;
    @(negedge clk); globalRstReq = 1'b0;
    busyCount = 1;
    check("R9 busy after request", {15'd0, globalRstBusy}, 16'd1);
    wrEn = 1'b1; addr = 2'd0; wrData = 16'h0000;
    @(negedge clk); wrEn = 1'b0;
    if (globalRstBusy) busyCount++;
    globalRstReq = 1'b1;
    @(negedge clk); globalRstReq = 1'b0;
    if (globalRstBusy) busyCount++;
    for (int k = 0; k < 2 * N_RST; k++) begin
      @(negedge clk);
      if (globalRstBusy) busyCount++;
    end
    check("R9 busy length", 16'(busyCount), 16'(N_RST));
    check("R9 busy cleared", {15'd0, globalRstBusy}, 16'd0);
    rd(2'd0, d); check("R9 ctrl default after hold", d, 16'h1100);
    rd(2'd1, d); check("R9 adv default after hold", d, 16'h0C00);

    // R11: hardware reset mid-run
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0005);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(2'd0, d); check("R11 ctrl after hard reset", d, 16'h1100);
    rd(2'd3, d); check("R11 manual after hard reset", d & 16'h0007, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule